// File: doc/BRIEF.md
# Stream ID Pattern Filter Bank

This block qualifies monitored events by their stream ID, once for each of a set of event counters. Each counter owns a filter configuration. The configuration has a match value and a mode bit. In exact mode, an event passes only when its stream ID equals the match value. In pattern mode, the match value also encodes which low bits to ignore: the lowest zero bit of the match value, together with the run of ones below it, marks the don't-care field. The stream ID bits above that field must equal the match value.

One event stream (`ev_valid`, `ev_sid`) feeds every filter at the same time. The block raises one qualified strobe for each counter, and it does so combinationally in the cycle the event is presented. Software writes the configuration through a simple write strobe that carries a counter index, a match word and an event-type word. The mode is taken from bit 29 of the event-type word. A write lands only if the target counter is disabled. In global mode, counter 0's configuration qualifies events for every counter, and the other configurations are kept but not consulted. After reset, every filter is set to the "unfiltered" setting: pattern mode with an all-ones match value.

Top module: `sidf_bank`

## Requirements
- R1: After reset, every filter is in pattern mode with an all-ones match value, so every valid event passes on every counter.
- R2: `ev_pass` is all zeros in any cycle where `ev_valid` is low.
- R3: With mode bit (event-type bit 29) equal to 0, counter i passes an event only when `ev_sid` equals the low SID_W bits of its match value.
- R4: With mode bit equal to 1, the ignored field is every bit up to and including the lowest zero bit of the match value. An event passes when all higher bits equal the match value (for example, match 0x42 passes 0x42 and 0x43 and rejects 0x40 and 0x44).
- R5: In pattern mode, a match value whose low SID_W bits are all ones passes every stream ID.
- R6: Match bits at or above SID_W, and every event-type bit other than bit 29, have no effect on filtering.
- R7: A configuration write to counter i is ignored while `ctr_en[i]` is high.
- R8: While `global_mode` is high, every counter uses counter 0's configuration, so all bits of `ev_pass` are equal.
- R9: A configuration write takes effect from the cycle after the clock edge that samples `cfg_we`. Filtering reacts to `ev_sid` in the same cycle.
- R10: A write to counter i leaves the configuration of every other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Counter addressed by the write |
| cfg_match | input | 32 | Match value word |
| cfg_type | input | 32 | Event-type word; bit 29 selects pattern mode |
| ctr_en | input | NUM_CTR | Per-counter enable; a high bit locks that configuration |
| global_mode | input | 1 | Use counter 0's filter for all counters |
| ev_valid | input | 1 | Event strobe |
| ev_sid | input | SID_W | Stream ID of the event |
| ev_pass | output | NUM_CTR | Qualified event strobe per counter |

## Verification
A corrupted match or mode register can only show up at `ev_pass`. It appears in the first cycle in which a valid event hits a stream ID that the right and wrong settings treat differently. The wrong setting stays visible until the next write is accepted. That is why the vector table puts stream IDs right at the edges of the don't-care field, just inside and just outside it. A lost or misrouted write shows one cycle after the write edge. So the bench checks the untouched counters after every write, and it checks the addressed counter both before and after the edge.

// File: rtl/sidf_pkg.sv
package sidf_pkg;
  localparam int WORD_W   = 32;
  localparam int SPAN_POS = 29;

  typedef enum logic {
    SIDF_EXACT   = 1'b0,
    SIDF_PATTERN = 1'b1
  } sidf_mode_e;
endpackage

// File: rtl/sidf_rst_sync.sv
module sidf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sidf_cfg_reg.sv
module sidf_cfg_reg
  import sidf_pkg::*;
#(
  parameter int SID_W   = 16,
  parameter int NUM_CTR = 4,
  parameter int IDX     = 0,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SID_W-1:0] wr_match,
  input  logic             wr_span,
  input  logic             ctr_en,
  output sidf_mode_e       mode_q,
  output logic [SID_W-1:0] match_q
);
  logic             load;
  sidf_mode_e       mode_d;
  logic [SID_W-1:0] match_d;

  always_comb begin
    load    = cfg_we && (cfg_idx == IDX_W'(IDX)) && !ctr_en;
    mode_d  = mode_q;
    match_d = match_q;
    if (load) begin
      mode_d  = wr_span ? SIDF_PATTERN : SIDF_EXACT;
      match_d = wr_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SIDF_PATTERN;
      match_q <= '1;
    end else if (load) begin
      mode_q  <= mode_d;
      match_q <= match_d;
    end
  end

  // R7: an enabled counter keeps its configuration
  a_r7_locked_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_en |=> ($stable(match_q) && $stable(mode_q)));

  // R10: writes addressed elsewhere leave this configuration alone
  a_r10_other_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && (cfg_idx == IDX_W'(IDX))) |=> ($stable(match_q) && $stable(mode_q)));
endmodule

// File: rtl/sidf_match.sv
module sidf_match
  import sidf_pkg::*;
#(
  parameter int SID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sidf_mode_e       mode,
  input  logic [SID_W-1:0] match,
  input  logic [SID_W-1:0] sid,
  output logic             hit
);
  logic [SID_W-1:0] ignore_mask;
  logic [SID_W-1:0] care_mask;

  always_comb begin
    // lowest zero bit and the ones below it; all ones wraps to a full mask
    ignore_mask = match ^ (match + SID_W'(1));
    care_mask   = (mode == SIDF_PATTERN) ? ~ignore_mask : '1;
    hit         = ((sid ^ match) & care_mask) == '0;
  end

  // R3: exact mode only hits on equality
  a_r3_exact_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SIDF_EXACT && hit) |-> (sid == match));

  // R5: all-ones pattern always hits
  a_r5_all_ones_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SIDF_PATTERN && (&match)) |-> hit);

  // R4: a zero in bit 0 ignores exactly that one bit
  a_r4_single_bit_field: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SIDF_PATTERN && !match[0]) |-> (hit == (sid[SID_W-1:1] == match[SID_W-1:1])));
endmodule

// File: rtl/sidf_bank.sv
module sidf_bank
  import sidf_pkg::*;
#(
  parameter int SID_W   = 16,
  parameter int NUM_CTR = 4,
  localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [31:0]        cfg_match,
  input  logic [31:0]        cfg_type,
  input  logic [NUM_CTR-1:0] ctr_en,
  input  logic               global_mode,
  input  logic               ev_valid,
  input  logic [SID_W-1:0]   ev_sid,
  output logic [NUM_CTR-1:0] ev_pass
);
  logic             rst_sync_n;
  sidf_mode_e       mode_q  [NUM_CTR];
  logic [SID_W-1:0] match_q [NUM_CTR];
  logic [NUM_CTR-1:0] hit;

  sidf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    if (SID_W < WORD_W) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^{cfg_match[WORD_W-1:SID_W], cfg_type[WORD_W-1:SPAN_POS+1],
                           cfg_type[SPAN_POS-1:0]};
    end else begin : g_unused_full
      logic unused_ty;
      assign unused_ty = ^{cfg_type[WORD_W-1:SPAN_POS+1], cfg_type[SPAN_POS-1:0]};
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      sidf_mode_e       sel_mode;
      logic [SID_W-1:0] sel_match;

      sidf_cfg_reg #(.SID_W(SID_W), .NUM_CTR(NUM_CTR), .IDX(i)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .wr_match (cfg_match[SID_W-1:0]),
        .wr_span  (cfg_type[SPAN_POS]),
        .ctr_en   (ctr_en[i]),
        .mode_q   (mode_q[i]),
        .match_q  (match_q[i])
      );

      always_comb begin
        sel_mode  = global_mode ? mode_q[0]  : mode_q[i];
        sel_match = global_mode ? match_q[0] : match_q[i];
      end

      sidf_match #(.SID_W(SID_W)) u_match (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .mode  (sel_mode),
        .match (sel_match),
        .sid   (ev_sid),
        .hit   (hit[i])
      );
    end
  endgenerate

  assign ev_pass = hit & {NUM_CTR{ev_valid}};

  // R2: no qualified strobe without an event
  a_r2_no_pass_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ev_valid |-> (ev_pass == '0));

  // R8: global mode makes all counters agree
  a_r8_global_uniform: assert property (@(posedge clk) disable iff (!rst_sync_n)
    global_mode |-> (ev_pass == {NUM_CTR{ev_pass[0]}}));
endmodule

// File: tb/sidf_bank_bench.sv
module sidf_bank_bench;
  localparam int SID_W   = 16;
  localparam int NUM_CTR = 4;
  localparam int NVEC    = 16;

  // {req[3:0], span, match[31:0], sid[15:0], expected}
  localparam logic [53:0] VEC [NVEC] = '{
    {4'd4, 1'b1, 32'h0000_0042, 16'h0042, 1'b1},
    {4'd4, 1'b1, 32'h0000_0042, 16'h0043, 1'b1},
    {4'd4, 1'b1, 32'h0000_0042, 16'h0040, 1'b0},
    {4'd4, 1'b1, 32'h0000_0042, 16'h0044, 1'b0},
    {4'd3, 1'b0, 32'h0000_0042, 16'h0042, 1'b1},
    {4'd3, 1'b0, 32'h0000_0042, 16'h0043, 1'b0},
    {4'd5, 1'b1, 32'hFFFF_FFFF, 16'h1234, 1'b1},
    {4'd4, 1'b1, 32'h0000_0007, 16'h000C, 1'b1},
    {4'd4, 1'b1, 32'h0000_0007, 16'h0010, 1'b0},
    {4'd6, 1'b0, 32'hABCD_1234, 16'h1234, 1'b1},
    {4'd6, 1'b0, 32'hABCD_1234, 16'h1235, 1'b0},
    {4'd6, 1'b1, 32'h0000_FFFF, 16'h0000, 1'b1},
    {4'd4, 1'b1, 32'h0000_7FFF, 16'h8000, 1'b1},
    {4'd4, 1'b1, 32'h0000_0000, 16'h0001, 1'b1},
    {4'd4, 1'b1, 32'h0000_0000, 16'h0002, 1'b0},
    {4'd3, 1'b0, 32'h0000_FFFF, 16'hFFFE, 1'b0}
  };

  logic               clk;
  logic               rst_n;
  logic               cfg_we;
  logic [1:0]         cfg_idx;
  logic [31:0]        cfg_match;
  logic [31:0]        cfg_type;
  logic [NUM_CTR-1:0] ctr_en;
  logic               global_mode;
  logic               ev_valid;
  logic [SID_W-1:0]   ev_sid;
  logic [NUM_CTR-1:0] ev_pass;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sidf_bank #(.SID_W(SID_W), .NUM_CTR(NUM_CTR)) u_sidf_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_match(cfg_match), .cfg_type(cfg_type), .ctr_en(ctr_en),
    .global_mode(global_mode), .ev_valid(ev_valid), .ev_sid(ev_sid),
    .ev_pass(ev_pass)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [NUM_CTR-1:0] act,
                     input logic [NUM_CTR-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] type_word(input logic span);
    return {2'b01, span, 29'h0000_00FF}; // junk bits outside bit 29 (R6)
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [31:0] m, input logic span);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_match = m; cfg_type = type_word(span);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_match = '0; cfg_type = '0;
    ctr_en = '0; global_mode = 1'b0; ev_valid = 1'b0; ev_sid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset configuration passes everything
    ev_valid = 1'b1;
    ev_sid = 16'h0000; #1 chk("R1", ev_pass, 4'b1111);
    ev_sid = 16'h1234; #1 chk("R1", ev_pass, 4'b1111);
    ev_sid = 16'hFFFF; #1 chk("R1", ev_pass, 4'b1111);
    // R2: no strobe without an event
    ev_valid = 1'b0; #1 chk("R2", ev_pass, 4'b0000);

    // Table on counter 0; R10: counters 1..3 keep pass-all
    for (int k = 0; k < NVEC; k++) begin
      wr(2'd0, VEC[k][48:17], VEC[k][49]);
      ev_valid = 1'b1; ev_sid = VEC[k][16:1];
      #1 chk($sformatf("R%0d vec%0d", VEC[k][53:50], k), {3'b000, ev_pass[0]},
             {3'b000, VEC[k][0]});
      chk("R10", {1'b0, ev_pass[3:1]}, 4'b0111);
    end

    // R7: write to an enabled counter is dropped
    ctr_en = 4'b0010;
    wr(2'd1, 32'h0000_0055, 1'b0);
    ev_valid = 1'b1; ev_sid = 16'h0066;
    #1 chk("R7 locked", {3'b000, ev_pass[1]}, 4'b0001);
    ctr_en = 4'b0000;
    wr(2'd1, 32'h0000_0055, 1'b0);
    ev_sid = 16'h0066; #1 chk("R7 unlocked", {3'b000, ev_pass[1]}, 4'b0000);
    ev_sid = 16'h0055; #1 chk("R7 unlocked", {3'b000, ev_pass[1]}, 4'b0001);

    // R9: new configuration appears after the sampling edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_match = 32'h0000_0010; cfg_type = type_word(1'b0);
    ev_sid = 16'h0011;
    #1 chk("R9 before edge", {3'b000, ev_pass[2]}, 4'b0001);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 chk("R9 after edge", {3'b000, ev_pass[2]}, 4'b0000);

    // R8: global mode uses counter 0 for all
    wr(2'd0, 32'h0000_0042, 1'b0);
    global_mode = 1'b1;
    ev_sid = 16'h0042; #1 chk("R8", ev_pass, 4'b1111);
    ev_sid = 16'h0055; #1 chk("R8", ev_pass, 4'b0000);
    ev_valid = 1'b0;   #1 chk("R2 global", ev_pass, 4'b0000);
    ev_valid = 1'b1; global_mode = 1'b0;
    ev_sid = 16'h0055; #1 chk("R8 off", ev_pass, 4'b1010);
    ev_sid = 16'h0010; #1 chk("R8 off", ev_pass, 4'b1100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule